// File: doc/BRIEF.md
# Strobe-Driven FIFO with Retransmit

This block is a first-in/first-out buffer for 9-bit words: an 8-bit byte plus one parity or control bit. Writers and readers load and unload it with separate active-low strobes and never supply an address. Two circular pointers pick the next slot to fill and the next slot to drain. All three strobe inputs are brought into the block's clock domain through a short synchronizer. The block acts once on each high-to-low transition of a strobe.

Three active-low status outputs report the fill level: empty, full and more-than-half-full. The empty and full states are used internally to drop reads that would underflow and writes that would overflow. A mode input selects single-device operation. In that mode a shared load/retransmit input rewinds the read pointer to the first stored word, so the data can be replayed. The shared half-full/expansion output also carries the half-full state only in that mode. Outside single-device mode, the shared input is ignored and the shared output idles high.

Top module: `strobe_fifo`

## Requirements
- R1: While rst_ni is low, both pointers are cleared, empty_n_o is 0, full_n_o is 1, half_xout_n_o is 1 and dout_o is 0.
- R2: Words read appear on dout_o in the order they were written, with all 9 bits intact. A read moves the word under the read pointer onto dout_o and advances the pointer.
- R3: Each high-to-low transition of wr_n_i stores exactly one word, however long the strobe is held low. The same holds for rd_n_i and reads.
- R4: full_n_o is 0 exactly when DEPTH words are stored. A write strobe while full is ignored: nothing is stored and neither pointer moves.
- R5: empty_n_o is 0 exactly when no words are stored. A read strobe while empty is ignored: dout_o holds its value and neither pointer moves.
- R6: In single-device mode (mode_single_i=1), half_xout_n_o is 0 when the stored count exceeds DEPTH/2 and 1 when it is DEPTH/2 or less.
- R7: In single-device mode, a high-to-low transition of load_rt_n_i sets the read pointer back to slot 0. Reading then restarts from the first word written since reset, and the flags follow from the restored pointer and the unchanged write pointer. A retransmit overrides a read in the same cycle.
- R8: With mode_single_i=0, load_rt_n_i has no effect on the read pointer, and half_xout_n_o stays 1.
- R9: A read and a write that take effect in the same cycle both take place. When the buffer is full, the read proceeds and the write is dropped. When it is empty, the write proceeds and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for strobe sampling and all state |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_single_i | input | 1 | 1 selects single-device mode |
| wr_n_i | input | 1 | Active-low write strobe |
| rd_n_i | input | 1 | Active-low read strobe |
| load_rt_n_i | input | 1 | Shared load/retransmit input, active-low retransmit in single-device mode |
| din_i | input | 9 | Write data, held while the write strobe is low |
| dout_o | output | 9 | Last word read |
| empty_n_o | output | 1 | Active-low empty flag |
| full_n_o | output | 1 | Active-low full flag |
| half_xout_n_o | output | 1 | Active-low half-full flag in single-device mode, else high |

## Verification
The bench uses an 8-deep instance. It sweeps the fill level from 0 to full and back, checking all three flags at every count, so the boundaries at 4/5 and 7/8 words are told apart from off-by-one errors. Strobes are applied alone, together, held long, at full and at empty. These patterns separate a correct edge detector and blocking rule from ones that store twice, underflow or drop the read side of a simultaneous pair. Retransmit is exercised after a partial drain in both modes, which shows that the rewind restores the first word and that it is ignored outside single-device mode.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  typedef struct packed {
    logic empty;
    logic full;
    logic half;
  } fifo_flags_t;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_n_i,
  output logic fall_o
);
  logic [SYNC:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[SYNC-1:0], strobe_n_i};
  end

  // one-cycle pulse on the high-to-low transition after synchronization
  assign fall_o = q[SYNC] & ~q[SYNC-1];
endmodule

// File: rtl/fifo_ptrs.sv
module fifo_ptrs
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_go_i,
  input  logic          rd_go_i,
  input  logic          rt_go_i,
  output logic          wr_en_o,
  output logic          rd_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output fifo_flags_t   flags_o
);
  logic [CW-1:0] wptr, rptr, cnt;

  assign cnt           = wptr - rptr;
  assign flags_o.empty = (cnt == '0);
  assign flags_o.full  = (cnt == CW'(DEPTH));
  assign flags_o.half  = (cnt >  CW'(DEPTH / 2));

  assign wr_en_o   = wr_go_i & ~flags_o.full;
  assign rd_en_o   = rd_go_i & ~flags_o.empty & ~rt_go_i;
  assign wr_addr_o = wptr[AW-1:0];
  assign rd_addr_o = rptr[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en_o) wptr <= wptr + 1'b1;
      if (rt_go_i)      rptr <= '0;
      else if (rd_en_o) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int DW = 9,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int DW = 9,
  parameter int DEPTH = 512,
  parameter int SYNC = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int NSTB = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_single_i,
  input  logic          wr_n_i,
  input  logic          rd_n_i,
  input  logic          load_rt_n_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_n_o,
  output logic          full_n_o,
  output logic          half_xout_n_o
);
  logic [NSTB-1:0] strb_n, fall;
  logic            wr_go, rd_go, rt_go, wr_en, rd_en;
  logic [AW-1:0]   wr_addr, rd_addr;
  fifo_flags_t     flags;

  assign strb_n = {load_rt_n_i, rd_n_i, wr_n_i};

  for (genvar g = 0; g < NSTB; g++) begin : g_edge
    strobe_edge #(.SYNC(SYNC)) u_edge (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .strobe_n_i(strb_n[g]),
      .fall_o    (fall[g])
    );
  end

  assign wr_go = fall[0];
  assign rd_go = fall[1];
  // shared pin acts as retransmit only in single-device mode
  assign rt_go = fall[2] & mode_single_i;

  fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_go_i  (wr_go),
    .rd_go_i  (rd_go),
    .rt_go_i  (rt_go),
    .wr_en_o  (wr_en),
    .rd_en_o  (rd_en),
    .wr_addr_o(wr_addr),
    .rd_addr_o(rd_addr),
    .flags_o  (flags)
  );

  fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(din_i),
    .rd_en_i  (rd_en),
    .rd_addr_i(rd_addr),
    .rd_data_o(dout_o)
  );

  assign empty_n_o     = ~flags.empty;
  assign full_n_o      = ~flags.full;
  assign half_xout_n_o = mode_single_i ? ~flags.half : 1'b1;
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int DW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_single_i,
  input logic          wr_go,
  input logic          rd_go,
  input logic          rt_go,
  input logic [DW-1:0] dout_o,
  input logic          empty_n_o,
  input logic          full_n_o,
  input logic          half_xout_n_o
);
  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_n_o && wr_go && !rd_go && !rt_go) |=> !full_n_o);

  // R5
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_n_o && rd_go && !wr_go && !rt_go) |=> (!empty_n_o && $stable(dout_o)));

  // R4
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!empty_n_o && !full_n_o));

  // R6
  half_not_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_xout_n_o |-> empty_n_o);

  // R8
  multi_half_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_single_i |-> half_xout_n_o);

  // R3
  write_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && !rd_go && !rt_go) |=> empty_n_o);
endmodule

bind strobe_fifo strobe_fifo_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_single_i(mode_single_i),
  .wr_go        (wr_go),
  .rd_go        (rd_go),
  .rt_go        (rt_go),
  .dout_o       (dout_o),
  .empty_n_o    (empty_n_o),
  .full_n_o     (full_n_o),
  .half_xout_n_o(half_xout_n_o)
);

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;
  localparam int DW = 9;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0, mode = 1, wr_n = 1, rd_n = 1, rt_n = 1;
  logic [DW-1:0] din = '0, dout;
  logic empty_n, full_n, half_n;
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  strobe_fifo #(.DW(DW), .DEPTH(DEPTH)) u_strobe_fifo (
    .clk_i(clk), .rst_ni(rst_n), .mode_single_i(mode),
    .wr_n_i(wr_n), .rd_n_i(rd_n), .load_rt_n_i(rt_n), .din_i(din),
    .dout_o(dout), .empty_n_o(empty_n), .full_n_o(full_n), .half_xout_n_o(half_n)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 37 + 5) ^ (i << 5));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input int cnt, input string req);
    logic [2:0] e;
    e = {(cnt == 0) ? 1'b0 : 1'b1, (cnt == DEPTH) ? 1'b0 : 1'b1,
         (mode && cnt > DEPTH / 2) ? 1'b0 : 1'b1};
    chk({empty_n, full_n, half_n} == e, req, int'({empty_n, full_n, half_n}), int'(e));
  endtask

  // strobe mask: bit0 write, bit1 read, bit2 retransmit
  task automatic pulse(input logic [2:0] m, input logic [DW-1:0] d, input int hold);
    @(negedge clk);
    din = d;
    wr_n = ~m[0]; rd_n = ~m[1]; rt_n = ~m[2];
    repeat (hold) @(negedge clk);
    wr_n = 1; rd_n = 1; rt_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk({empty_n, full_n, half_n} == 3'b011, "R1 flags", int'({empty_n, full_n, half_n}), 3);
    chk(dout == '0, "R1 dout", int'(dout), 0);
    rst_n = 1;
    @(negedge clk);

    // R4 R6 fill sweep
    for (int i = 0; i < DEPTH; i++) begin
      pulse(3'b001, pat(i), 2);
      chk_flags(i + 1, "R4/R6 fill");
    end
    // R4 write while full ignored
    pulse(3'b001, pat(99), 2);
    chk_flags(DEPTH, "R4 overflow");
    // R2 R6 drain sweep
    for (int i = 0; i < DEPTH; i++) begin
      pulse(3'b010, '0, 2);
      chk(dout == pat(i), "R2 order", int'(dout), int'(pat(i)));
      chk_flags(DEPTH - 1 - i, "R5/R6 drain");
    end
    // R5 read while empty ignored
    pulse(3'b010, '0, 2);
    chk(dout == pat(DEPTH - 1), "R5 dout held", int'(dout), int'(pat(DEPTH - 1)));
    chk_flags(0, "R5 underflow");

    // R3 long strobe stores one word
    pulse(3'b001, pat(40), 7);
    chk_flags(1, "R3 one write");
    pulse(3'b010, '0, 7);
    chk(dout == pat(40), "R3 data", int'(dout), int'(pat(40)));
    chk_flags(0, "R3 one read");

    // R9 simultaneous in the middle
    for (int i = 10; i < 13; i++) pulse(3'b001, pat(i), 2);
    pulse(3'b011, pat(13), 2);
    chk(dout == pat(10), "R9 both data", int'(dout), int'(pat(10)));
    chk_flags(3, "R9 both count");
    for (int i = 11; i < 14; i++) begin
      pulse(3'b010, '0, 2);
      chk(dout == pat(i), "R9 drain", int'(dout), int'(pat(i)));
    end
    chk_flags(0, "R9 drained");
    // R9 simultaneous at full
    for (int i = 20; i < 20 + DEPTH; i++) pulse(3'b001, pat(i), 2);
    pulse(3'b011, pat(50), 2);
    chk(dout == pat(20), "R9 full read", int'(dout), int'(pat(20)));
    chk_flags(DEPTH - 1, "R9 full write dropped");
    for (int i = 21; i < 20 + DEPTH; i++) begin
      pulse(3'b010, '0, 2);
      chk(dout == pat(i), "R9 full drain", int'(dout), int'(pat(i)));
    end
    // R9 simultaneous at empty
    pulse(3'b011, pat(60), 2);
    chk(dout == pat(19 + DEPTH), "R9 empty read dropped", int'(dout), int'(pat(19 + DEPTH)));
    chk_flags(1, "R9 empty write");
    pulse(3'b010, '0, 2);
    chk(dout == pat(60), "R9 empty data", int'(dout), int'(pat(60)));

    // R7 retransmit
    do_reset();
    chk_flags(0, "R1 after reset");
    for (int i = 70; i < 75; i++) pulse(3'b001, pat(i), 2);
    for (int i = 70; i < 73; i++) pulse(3'b010, '0, 2);
    chk_flags(2, "R7 before rewind");
    pulse(3'b100, '0, 2);
    chk_flags(5, "R7 flags after rewind");
    for (int i = 70; i < 75; i++) begin
      pulse(3'b010, '0, 2);
      chk(dout == pat(i), "R7 replay", int'(dout), int'(pat(i)));
    end
    chk_flags(0, "R7 replay done");
    // R7 retransmit overrides coincident read
    pulse(3'b110, '0, 2);
    chk(dout == pat(74), "R7 read overridden", int'(dout), int'(pat(74)));
    chk_flags(5, "R7 rewind with read");

    // R8 multi-device mode
    do_reset();
    mode = 0;
    for (int i = 80; i < 86; i++) pulse(3'b001, pat(i), 2);
    chk(half_n == 1'b1, "R8 half idle", int'(half_n), 1);
    for (int i = 80; i < 82; i++) pulse(3'b010, '0, 2);
    pulse(3'b100, '0, 2);
    chk_flags(4, "R8 rewind ignored");
    for (int i = 82; i < 86; i++) begin
      pulse(3'b010, '0, 2);
      chk(dout == pat(i), "R8 no replay", int'(dout), int'(pat(i)));
    end
    chk_flags(0, "R8 drained");
    mode = 1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule